// File: doc/BRIEF.md
# Memory-Mapped Register Bank with Programmable Stall

This block is a target on a simple memory-mapped bus. It holds a parameterised number of 32-bit registers. The master drives a word index, a read strobe, a write strobe, write data and one enable bit per byte lane. The block answers with read data, a 2-bit completion code and a stall output. Each new request is held off for a fixed number of cycles, set by a parameter. During that time the master must keep every request signal steady. The transfer then completes on the first clock edge where the request is present and the stall output is low. Read data and the completion code are valid during that same cycle.

A small state machine sets the timing. It has three states:
- **IDLE**: no stall is in progress. A request arriving here either completes at once (zero stall) or raises the stall output. It then moves to HOLD, or to GRANT when the stall is one cycle long.
- **HOLD**: the stall output stays high while a down-counter runs. When the counter reaches its last step, the machine moves to GRANT. If the master drops its request, the machine returns to IDLE.
- **GRANT**: the stall output is low and the held request is accepted. The machine then always returns to IDLE, so the next request gets a full stall of its own.

An index beyond the register count is answered with an error code. Asserting read and write together is treated as a write and raises a sticky flag.

Top module: `mmio_regbank`

## Requirements
- R1: A synchronous reset clears every register to zero and clears the conflict flag. While reset is high, the stall output is low even if a request is present.
- R2: Every new request, including one that directly follows a completed transfer, sees the stall output high for exactly WAIT_CYCLES consecutive cycles, followed by one cycle with the stall low.
- R3: A transfer takes effect only on a clock edge where a request is present and the stall is low. A write that is withdrawn while still stalled leaves the target register unchanged, and no response is given while stalled.
- R4: Write-enable bit i controls data bits 8i+7 down to 8i. For example, 4'b0001 changes only bits 7:0 and 4'b1000 changes only bits 31:24; all other bytes keep their value.
- R5: The read data output carries the addressed register during the cycle in which a read is accepted, and is zero in every other cycle.
- R6: The completion code is 2'b00 (okay) for an accepted transfer whose word index is below NUM_REGS. It is 2'b10 (target error) for an accepted transfer at a higher index, and 2'b00 when nothing is accepted. The codes 2'b01 and 2'b11 are never driven.
- R7: At an out-of-range index, a read returns zero and a write changes no register, including the register whose index equals the low address bits.
- R8: An accepted transfer with read and write both high performs the write, returns zero read data, and sets the conflict flag. The flag stays set until reset.
- R9: With WAIT_CYCLES set to 0, the stall output never rises and every request completes in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_addr | input | ADDR_W | Word index of the target register |
| req_read | input | 1 | Read request |
| req_write | input | 1 | Write request |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte-lane write enables |
| rsp_rdata | output | DATA_W | Read data, valid in the accepting cycle |
| rsp_code | output | 2 | Completion code, valid in the accepting cycle |
| stall | output | 1 | High while the request must be held |
| conflict_err | output | 1 | Sticky flag for read and write asserted together |

## Verification
There are two kinds of internal fault. If the state machine or its counter goes wrong, the error appears at the ports within the same transfer: the number of high stall cycles differs from WAIT_CYCLES, or a response shows up while the stall is high. If a register byte is corrupted by a wrong lane, a wrong index or an out-of-range alias, nothing shows until that register is next read. For that reason the random phase reads back often, and the directed cases read the neighbouring and aliased registers right after each special write. A conflict flag that fails to stick is caught on the first transfer after the one that should have set it.

// File: rtl/mmio_pkg.sv
`timescale 1ns/1ps
package mmio_pkg;

    typedef enum logic [1:0] {
        RSP_OKAY   = 2'b00,
        RSP_RSVD   = 2'b01,
        RSP_SLVERR = 2'b10,
        RSP_DECERR = 2'b11
    } resp_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_HOLD  = 2'b01,
        ST_GRANT = 2'b10
    } stall_st_e;

endpackage

// File: rtl/mmio_stall_fsm.sv
`timescale 1ns/1ps
module mmio_stall_fsm #(
    parameter int WAIT_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic stall,
    output logic accept
);
    import mmio_pkg::*;

    localparam int CW    = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
    localparam int RELOAD = (WAIT_CYCLES > 0) ? WAIT_CYCLES - 1 : 0;

    stall_st_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req && (WAIT_CYCLES != 0)) begin
                    if (WAIT_CYCLES == 1) begin
                        state_d = ST_GRANT;
                    end else begin
                        state_d = ST_HOLD;
                        cnt_d   = CW'(RELOAD);
                    end
                end
            end
            ST_HOLD: begin
                if (!req) begin
                    state_d = ST_IDLE;
                end else if (cnt_q == CW'(1)) begin
                    state_d = ST_GRANT;
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            ST_GRANT: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        stall  = 1'b0;
        accept = 1'b0;
        if (!rst) begin
            unique case (state_q)
                ST_IDLE: begin
                    stall  = req && (WAIT_CYCLES != 0);
                    accept = req && (WAIT_CYCLES == 0);
                end
                ST_HOLD: begin
                    stall  = req;
                end
                ST_GRANT: begin
                    accept = req;
                end
                default: begin
                    stall  = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/mmio_reg_array.sv
`timescale 1ns/1ps
module mmio_reg_array #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [IDX_W-1:0]      widx,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [DATA_W/8-1:0]   be,
    input  logic [IDX_W-1:0]      ridx,
    output logic [DATA_W-1:0]     rdata
);
    localparam int LANES = DATA_W / 8;

    logic [NUM_REGS*DATA_W-1:0] flat;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        logic hit;
        assign hit = we && (widx == IDX_W'(g));
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [7:0] lane_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    lane_q <= 8'h00;
                end else if (hit && be[l]) begin
                    lane_q <= wdata[l*8 +: 8];
                end
            end
            assign flat[g*DATA_W + l*8 +: 8] = lane_q;
        end
    end

    always_comb begin
        if (32'(ridx) < NUM_REGS) begin
            rdata = flat[ridx*DATA_W +: DATA_W];
        end else begin
            rdata = '0;
        end
    end

endmodule

// File: rtl/mmio_regbank.sv
`timescale 1ns/1ps
module mmio_regbank #(
    parameter int NUM_REGS    = 8,
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32,
    parameter int WAIT_CYCLES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_read,
    input  logic                req_write,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_be,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [1:0]          rsp_code,
    output logic                stall,
    output logic                conflict_err
);
    import mmio_pkg::*;

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic              accept;
    logic              in_range;
    logic              wr_en;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] arr_rdata;
    logic              conflict_q;

    assign in_range = 32'(req_addr) < NUM_REGS;
    assign idx      = req_addr[IDX_W-1:0];
    assign wr_en    = accept && req_write && in_range;

    mmio_stall_fsm #(
        .WAIT_CYCLES (WAIT_CYCLES)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .req    (req_read || req_write),
        .stall  (stall),
        .accept (accept)
    );

    mmio_reg_array #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .widx  (idx),
        .wdata (req_wdata),
        .be    (req_be),
        .ridx  (idx),
        .rdata (arr_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            conflict_q <= 1'b0;
        end else if (accept && req_read && req_write) begin
            conflict_q <= 1'b1;
        end
    end

    always_comb begin
        rsp_rdata = '0;
        rsp_code  = RSP_OKAY;
        if (accept) begin
            rsp_code = in_range ? RSP_OKAY : RSP_SLVERR;
            if (req_read && !req_write && in_range) begin
                rsp_rdata = arr_rdata;
            end
        end
    end

    assign conflict_err = conflict_q;

endmodule

// File: rtl/mmio_regbank_chk.sv
`timescale 1ns/1ps
module mmio_regbank_chk #(
    parameter int NUM_REGS    = 8,
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32,
    parameter int WAIT_CYCLES = 2
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   req_addr,
    input logic                req_read,
    input logic                req_write,
    input logic [DATA_W-1:0]   req_wdata,
    input logic [DATA_W/8-1:0] req_be,
    input logic [DATA_W-1:0]   rsp_rdata,
    input logic [1:0]          rsp_code,
    input logic                stall,
    input logic                conflict_err
);
    logic [3:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 4'd0;
        end else if (stall) begin
            run_q <= (run_q == 4'hF) ? run_q : run_q + 4'd1;
        end else begin
            run_q <= 4'd0;
        end
    end

    // R1
    rst_stall_low_chk: assert property (@(posedge clk) rst |-> !stall);

    // R2
    stall_run_len_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> (32'(run_q) < WAIT_CYCLES));

    // R6
    code_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_code == 2'b00) || (rsp_code == 2'b10));

    // R6
    err_code_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_code == 2'b10) |-> ((req_read || req_write) && !stall && (32'(req_addr) >= NUM_REGS)));

    // R5
    rdata_only_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_rdata != '0) |-> (req_read && !req_write && !stall));

    // R8
    conflict_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        conflict_err |=> conflict_err);

endmodule

bind mmio_regbank mmio_regbank_chk #(
    .NUM_REGS    (NUM_REGS),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .WAIT_CYCLES (WAIT_CYCLES)
) u_chk (.*);

// File: tb/test_mmio_regbank.sv
`timescale 1ns/1ps
module test_mmio_regbank;
    localparam int NREG = 8;
    localparam int AW   = 4;
    localparam int DW   = 32;
    localparam int BL   = DW / 8;
    localparam int WC   = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst;
    logic [AW-1:0] addr;
    logic          rd, wr, w0_en;
    logic [DW-1:0] wdata;
    logic [BL-1:0] be;

    logic [DW-1:0] rdata, w0_rdata;
    logic [1:0]    code, w0_code;
    logic          stall, w0_stall, cerr, w0_cerr;

    mmio_regbank #(.NUM_REGS(NREG), .ADDR_W(AW), .DATA_W(DW), .WAIT_CYCLES(WC)) i_mmio_regbank (
        .clk(clk), .rst(rst), .req_addr(addr), .req_read(rd), .req_write(wr),
        .req_wdata(wdata), .req_be(be), .rsp_rdata(rdata), .rsp_code(code),
        .stall(stall), .conflict_err(cerr));

    mmio_regbank #(.NUM_REGS(NREG), .ADDR_W(AW), .DATA_W(DW), .WAIT_CYCLES(0)) i_mmio_regbank_w0 (
        .clk(clk), .rst(rst), .req_addr(addr), .req_read(rd && w0_en), .req_write(wr && w0_en),
        .req_wdata(wdata), .req_be(be), .rsp_rdata(w0_rdata), .rsp_code(w0_code),
        .stall(w0_stall), .conflict_err(w0_cerr));

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    logic [DW-1:0] model [NREG];
    bit model_err;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                             input logic [BL-1:0] m);
        logic [DW-1:0] r = old;
        for (int l = 0; l < BL; l++) if (m[l]) r[l*8 +: 8] = nw[l*8 +: 8];
        return r;
    endfunction

    task automatic xfer(input bit r, input bit w, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [BL-1:0] b);
        logic [DW-1:0] exp_rd;
        logic [1:0]    exp_code;
        bit            inr;
        int            stalls;
        inr      = int'(a) < NREG;
        exp_rd   = (r && !w && inr) ? model[a[2:0]] : '0;
        exp_code = inr ? 2'b00 : 2'b10;
        @(negedge clk);
        addr = a; rd = r; wr = w; wdata = d; be = b; w0_en = 1'b1;
        #1;
        chk(!w0_stall, "R9 zero-wait stall", 32'(w0_stall), 32'd0);
        chk(w0_rdata == exp_rd, "R9 zero-wait read data", w0_rdata, exp_rd);
        chk(w0_code == exp_code, "R9 zero-wait code", 32'(w0_code), 32'(exp_code));
        stalls = 0;
        while (stall && stalls < 20) begin
            chk(code == 2'b00 && rdata == '0, "R3 no response while stalled", rdata, 32'd0);
            stalls++;
            @(negedge clk);
            #1;
        end
        chk(stalls == WC, "R2 stall length", 32'(stalls), 32'(WC));
        chk(rdata == exp_rd, "R5 read data in accept cycle", rdata, exp_rd);
        chk(code == exp_code, "R6 completion code", 32'(code), 32'(exp_code));
        if (w && inr) model[a[2:0]] = merge(model[a[2:0]], d, b);
        if (r && w) model_err = 1'b1;
        @(negedge clk);
        rd = 1'b0; wr = 1'b0;
        #1;
        chk(cerr == model_err, "R8 conflict flag", 32'(cerr), 32'(model_err));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rd = 1'b1; addr = '0;
        #1;
        chk(!stall, "R1 stall low during reset", 32'(stall), 32'd0);
        repeat (2) @(negedge clk);
        rst = 1'b0; rd = 1'b0;
        for (int i = 0; i < NREG; i++) model[i] = '0;
        model_err = 1'b0;
        #1;
        chk(!cerr, "R1 conflict flag cleared", 32'(cerr), 32'd0);
        chk(!stall, "R1 stall low after reset", 32'(stall), 32'd0);
    endtask

    task automatic read_all(input string why);
        for (int i = 0; i < NREG; i++) xfer(1'b1, 1'b0, AW'(i), '0, '0);
        if (why.len() == 0) $display("read-back done");
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog expired actual=hung expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; rd = 1'b0; wr = 1'b0; addr = '0; wdata = '0; be = '0; w0_en = 1'b1;
        for (int i = 0; i < NREG; i++) model[i] = '0;
        model_err = 1'b0;
        rd = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(!stall, "R1 stall low in reset with request", 32'(stall), 32'd0);
        chk(!cerr, "R1 conflict flag at reset", 32'(cerr), 32'd0);
        @(negedge clk);
        rst = 1'b0; rd = 1'b0;
        // R1: all registers read zero after reset
        read_all("R1");

        // R4: byte lanes
        xfer(1'b0, 1'b1, 4'd0, 32'h11223344, 4'b1111);
        xfer(1'b0, 1'b1, 4'd1, 32'hAABBCCDD, 4'b0001);
        xfer(1'b0, 1'b1, 4'd2, 32'hAABBCCDD, 4'b1000);
        xfer(1'b0, 1'b1, 4'd0, 32'h99887766, 4'b0110);
        xfer(1'b1, 1'b0, 4'd1, '0, '0);
        chk(model[1] == 32'h000000DD, "R4 low lane only", model[1], 32'h000000DD);
        xfer(1'b1, 1'b0, 4'd2, '0, '0);
        xfer(1'b1, 1'b0, 4'd0, '0, '0);
        chk(model[0] == 32'h11887744, "R4 middle lanes", model[0], 32'h11887744);

        // R7: out-of-range write and read, no aliasing onto register 1
        xfer(1'b0, 1'b1, 4'd9, 32'hFFFFFFFF, 4'b1111);
        xfer(1'b1, 1'b0, 4'd9, '0, '0);
        xfer(1'b1, 1'b0, 4'd1, '0, '0);
        xfer(1'b1, 1'b0, 4'd15, '0, '0);

        // R3: write withdrawn while stalled has no effect
        @(negedge clk);
        w0_en = 1'b0; addr = 4'd3; wr = 1'b1; wdata = 32'hDEADBEEF; be = 4'b1111;
        @(negedge clk);
        wr = 1'b0;
        xfer(1'b1, 1'b0, 4'd3, '0, '0);
        chk(model[3] == 32'h0, "R3 withdrawn write ignored", model[3], 32'h0);

        // R8: read and write together
        xfer(1'b1, 1'b1, 4'd4, 32'h0BADF00D, 4'b1111);
        xfer(1'b1, 1'b0, 4'd4, '0, '0);
        xfer(1'b0, 1'b1, 4'd5, 32'h12345678, 4'b0011);
        chk(cerr == 1'b1, "R8 flag still set", 32'(cerr), 32'd1);

        // random phase
        for (int k = 0; k < 300; k++) begin
            int op;
            logic [AW-1:0] a;
            op = $urandom_range(0, 19);
            a  = AW'($urandom_range(0, 11));
            if (op < 10)       xfer(1'b1, 1'b0, a, '0, '0);
            else if (op < 19)  xfer(1'b0, 1'b1, a, $urandom, BL'($urandom));
            else               xfer(1'b1, 1'b1, a, $urandom, BL'($urandom));
        end
        read_all("R5");

        // R1: mid-run reset clears everything
        do_reset();
        read_all("R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule